// File: doc/BRIEF.md
# Multilevel Resistive Cell Write-Verify Controller

This block sequences the programming of one multilevel resistive memory cell, or of a group of cells that share one target resistance window, by alternating write pulses with verify reads. An operation opens with a coarse phase of SET pulses at fixed per-range drive levels. It then moves to a fine phase, in which each verify result picks the next step. A cell above the window gets a SET pulse with a higher bitline level. A cell below the window gets a RESET pulse with a higher sourceline level. Once the bitline has reached its ceiling, each further SET raises the wordline by one code instead.

All drive levels are 10-bit DAC codes, one LSB standing for 10 mV. The levels come from a per-range parameter table that is computed inside the block. Each phase spends from its own pulse budget. The operation ends with a done flag when a verify read reports the cell inside the window. It ends with a fail flag when a phase needs a pulse beyond its budget. The analog drivers and the sense path sit outside the block and talk to it through two request/acknowledge handshakes, and only one request is ever open at a time.

The state machine has five states:

- `ST_IDLE`: waits for a start strobe.
- `ST_CPULSE`: a coarse SET pulse is requested.
- `ST_CVERIFY`: a verify read after a coarse pulse is requested.
- `ST_FPULSE`: a fine SET or RESET pulse is requested.
- `ST_FVERIFY`: a verify read after a fine pulse is requested.

The transitions are:

- `ST_IDLE`→`ST_CPULSE` on start with a non-zero coarse budget.
- `ST_IDLE`→`ST_IDLE` with fail set, on start with a zero coarse budget.
- `ST_CPULSE`→`ST_CVERIFY` and `ST_FPULSE`→`ST_FVERIFY` on pulse acknowledge.
- `ST_CVERIFY`→`ST_IDLE` (done) when the result is in the window.
- `ST_CVERIFY`→`ST_CPULSE` when the result is above and coarse budget is left.
- `ST_CVERIFY`→`ST_FPULSE` when the result is below and fine budget is left.
- `ST_FVERIFY`→`ST_FPULSE` when the result is above or below and fine budget is left.
- `ST_FVERIFY`→`ST_IDLE` when the result is in the window (done) or the budget is spent (fail).
- A verify state stays where it is when the result shows no flag.

Top module: `rram_wv_ctrl`

## Requirements
- R1: A start strobe accepted in idle latches the range index and both limits, raises busy_o, and requests a coarse SET pulse (pulse_kind_o = 0 means SET, 1 means RESET) with bitline code 200, sourceline code 0 and wordline code 286 + 4*range.
- R2: Only one request is open at a time. A pulse acknowledge is followed by a verify request, and no new pulse is requested before that verify is acknowledged. The codes hold still while a pulse request waits.
- R3: A verify result is decoded with in-window taking priority over above, and above over below. A result with no flag set causes a fresh verify request and no pulse.
- R4: After a coarse verify, in-window ends the operation with done. Above issues another coarse SET. Below enters the fine phase with a RESET pulse.
- R5: The first fine SET of an operation drives bitline code 120 + 10*range. Each later fine SET adds 20, capped at 400. Sourceline is 0 during a SET.
- R6: The first fine RESET drives sourceline code 150 + 10*range. Each later one adds 10, capped at 350. Bitline is 0 during a RESET, and the wordline carries the current fine wordline level.
- R7: The fine wordline level starts at the coarse wordline code of the range. It rises by one code (10 mV) on each fine SET that follows a SET already issued at the bitline ceiling, and the bitline stays at 400.
- R8: When another coarse pulse is needed and the number of coarse pulses equals the coarse limit, the operation ends with fail and issues no pulse. A coarse limit of 0 fails at start.
- R9: When a fine pulse is needed and the number of fine pulses equals the fine limit, the operation ends with fail and issues no pulse.
- R10: done_o and fail_o are never both high. The one that is set stays set with busy_o low until the next accepted start clears it.
- R11: A start strobe while busy_o is high is ignored: range, limits and the pulse sequence are unchanged.
- R12: After reset the block is idle, with every request, flag and code output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| range_i | input | RANGE_W | Target range index |
| coarse_limit_i | input | CNT_W | Maximum coarse pulses |
| fine_limit_i | input | CNT_W | Maximum fine pulses |
| pulse_req_o | output | 1 | Pulse request |
| pulse_kind_o | output | 1 | 0 = SET, 1 = RESET |
| bl_code_o | output | DAC_W | Bitline DAC code |
| sl_code_o | output | DAC_W | Sourceline DAC code |
| wl_code_o | output | DAC_W | Wordline DAC code |
| pulse_ack_i | input | 1 | Pulse acknowledge |
| verify_req_o | output | 1 | Verify read request |
| verify_ack_i | input | 1 | Verify acknowledge, result valid |
| vfy_in_i | input | 1 | Cell inside window |
| vfy_above_i | input | 1 | Cell above window |
| vfy_below_i | input | 1 | Cell below window |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation ended in window |
| fail_o | output | 1 | Operation ended over budget |

## Verification
The bench drives long fine-phase runs, which push the bitline up to its 400 ceiling and then bring in the wordline escalation, and which hold the sourceline at its 350 cap. A design that kept stepping past a ceiling, or that raised the wordline too early, would show wrong codes on the pulse that follows. Both budgets are run down to equality, including a zero coarse budget and a zero fine budget. An off-by-one check would show up there as one pulse too many or too few before the fail flag. The bench also feeds verify results that carry no flag, to catch a design that pulses anyway. It sends a second start in the middle of an operation, to catch a design that reloads its range or limits while busy.

// File: rtl/rram_wv_pkg.sv
package rram_wv_pkg;

    localparam int DAC_W = 10;

    typedef logic [DAC_W-1:0] dac_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CPULSE,
        ST_CVERIFY,
        ST_FPULSE,
        ST_FVERIFY
    } wv_state_e;

    typedef enum logic {
        PK_SET   = 1'b0,
        PK_RESET = 1'b1
    } pulse_kind_e;

    typedef struct packed {
        dac_t coarse_bl;
        dac_t wl_start;
        dac_t fbl_start;
        dac_t fbl_step;
        dac_t fbl_ceil;
        dac_t sl_start;
        dac_t sl_step;
        dac_t sl_ceil;
    } range_cfg_t;

    // Per-range drive levels, one LSB = 10 mV
    function automatic range_cfg_t range_cfg(int unsigned r);
        range_cfg_t c;
        c.coarse_bl = dac_t'(200);
        c.wl_start  = dac_t'(286 + 4 * r);
        c.fbl_start = dac_t'(120 + 10 * r);
        c.fbl_step  = dac_t'(20);
        c.fbl_ceil  = dac_t'(400);
        c.sl_start  = dac_t'(150 + 10 * r);
        c.sl_step   = dac_t'(10);
        c.sl_ceil   = dac_t'(350);
        return c;
    endfunction

endpackage

// File: rtl/wv_range_table.sv
module wv_range_table
    import rram_wv_pkg::*;
#(
    parameter int NUM_RANGES = 4,
    parameter int RANGE_W    = 2
) (
    input  logic [RANGE_W-1:0] idx_i,
    output range_cfg_t         cfg_o
);

    range_cfg_t tbl [NUM_RANGES];

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_entry
        assign tbl[g] = range_cfg(g);
    end

    always_comb begin
        if (int'(idx_i) < NUM_RANGES) cfg_o = tbl[idx_i];
        else                          cfg_o = tbl[0];
    end

endmodule

// File: rtl/wv_pulse_budget.sv
module wv_pulse_budget #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             spent_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    assign spent_o = (cnt_q >= limit_i);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i && !clr_i |-> !spent_o);

endmodule

// File: rtl/wv_level_step.sv
module wv_level_step #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         adv_i,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] step_i,
    input  logic [W-1:0] ceil_i,
    output logic [W-1:0] lvl_o,
    output logic         at_ceil_o
);

    logic [W-1:0] lvl_q;
    logic         seen_q;
    logic [W:0]   sum;

    assign sum = {1'b0, lvl_q} + {1'b0, step_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            seen_q <= 1'b0;
        end else if (clr_i) begin
            lvl_q  <= '0;
            seen_q <= 1'b0;
        end else if (adv_i) begin
            if (!seen_q) begin
                lvl_q  <= start_i;
                seen_q <= 1'b1;
            end else if (sum > {1'b0, ceil_i}) begin
                lvl_q <= ceil_i;
            end else begin
                lvl_q <= sum[W-1:0];
            end
        end
    end

    assign lvl_o     = lvl_q;
    assign at_ceil_o = seen_q && (lvl_q >= ceil_i);

    // R5
    lvl_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !clr_i && seen_q |=> lvl_q <= $past(ceil_i));

endmodule

// File: rtl/rram_wv_ctrl.sv
module rram_wv_ctrl
    import rram_wv_pkg::*;
#(
    parameter int NUM_RANGES = 4,
    parameter int CNT_W      = 8,
    parameter int RANGE_W    = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [RANGE_W-1:0] range_i,
    input  logic [CNT_W-1:0]   coarse_limit_i,
    input  logic [CNT_W-1:0]   fine_limit_i,
    output logic               pulse_req_o,
    output logic               pulse_kind_o,
    output logic [DAC_W-1:0]   bl_code_o,
    output logic [DAC_W-1:0]   sl_code_o,
    output logic [DAC_W-1:0]   wl_code_o,
    input  logic               pulse_ack_i,
    output logic               verify_req_o,
    input  logic               verify_ack_i,
    input  logic               vfy_in_i,
    input  logic               vfy_above_i,
    input  logic               vfy_below_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               fail_o
);

    localparam dac_t WL_MAX = '1;

    wv_state_e          state_q, state_d;
    logic [RANGE_W-1:0] range_q;
    logic [CNT_W-1:0]   climit_q, flimit_q;
    pulse_kind_e        kind_q, kind_d;
    dac_t               wl_lvl_q;
    logic               done_q, fail_q;

    logic start_acc, set_done, set_fail;
    logic c_inc, f_inc, c_spent, f_spent;
    logic bl_adv, sl_adv, wl_bump, wl_load;
    logic res_in, res_above, res_below;
    dac_t bl_lvl, sl_lvl;
    logic bl_at_ceil, sl_at_ceil;
    range_cfg_t cfg;

    wv_range_table #(.NUM_RANGES(NUM_RANGES), .RANGE_W(RANGE_W)) u_tbl (
        .idx_i (range_q),
        .cfg_o (cfg)
    );

    wv_pulse_budget #(.CNT_W(CNT_W)) u_cbud (
        .clk, .rst_n, .clr_i(start_acc), .inc_i(c_inc),
        .limit_i(climit_q), .spent_o(c_spent)
    );

    wv_pulse_budget #(.CNT_W(CNT_W)) u_fbud (
        .clk, .rst_n, .clr_i(start_acc), .inc_i(f_inc),
        .limit_i(flimit_q), .spent_o(f_spent)
    );

    wv_level_step #(.W(DAC_W)) u_bl (
        .clk, .rst_n, .clr_i(start_acc), .adv_i(bl_adv),
        .start_i(cfg.fbl_start), .step_i(cfg.fbl_step), .ceil_i(cfg.fbl_ceil),
        .lvl_o(bl_lvl), .at_ceil_o(bl_at_ceil)
    );

    wv_level_step #(.W(DAC_W)) u_sl (
        .clk, .rst_n, .clr_i(start_acc), .adv_i(sl_adv),
        .start_i(cfg.sl_start), .step_i(cfg.sl_step), .ceil_i(cfg.sl_ceil),
        .lvl_o(sl_lvl), .at_ceil_o(sl_at_ceil)
    );

    // verify decode: in-window over above over below
    assign res_in    = vfy_in_i;
    assign res_above = !vfy_in_i && vfy_above_i;
    assign res_below = !vfy_in_i && !vfy_above_i && vfy_below_i;

    assign c_inc = (state_q == ST_CPULSE) && pulse_ack_i;
    assign f_inc = (state_q == ST_FPULSE) && pulse_ack_i;

    // next state and step strobes
    always_comb begin
        state_d   = state_q;
        kind_d    = kind_q;
        start_acc = 1'b0;
        set_done  = 1'b0;
        set_fail  = 1'b0;
        bl_adv    = 1'b0;
        sl_adv    = 1'b0;
        wl_bump   = 1'b0;
        wl_load   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    start_acc = 1'b1;
                    if (coarse_limit_i == '0) begin
                        set_fail = 1'b1;
                    end else begin
                        state_d = ST_CPULSE;
                        kind_d  = PK_SET;
                    end
                end
            end
            ST_CPULSE: begin
                if (pulse_ack_i) state_d = ST_CVERIFY;
            end
            ST_CVERIFY: begin
                if (verify_ack_i) begin
                    if (res_in) begin
                        set_done = 1'b1;
                        state_d  = ST_IDLE;
                    end else if (res_above) begin
                        if (c_spent) begin
                            set_fail = 1'b1;
                            state_d  = ST_IDLE;
                        end else begin
                            state_d = ST_CPULSE;
                            kind_d  = PK_SET;
                        end
                    end else if (res_below) begin
                        wl_load = 1'b1;
                        if (f_spent) begin
                            set_fail = 1'b1;
                            state_d  = ST_IDLE;
                        end else begin
                            sl_adv  = 1'b1;
                            kind_d  = PK_RESET;
                            state_d = ST_FPULSE;
                        end
                    end
                end
            end
            ST_FPULSE: begin
                if (pulse_ack_i) state_d = ST_FVERIFY;
            end
            ST_FVERIFY: begin
                if (verify_ack_i) begin
                    if (res_in) begin
                        set_done = 1'b1;
                        state_d  = ST_IDLE;
                    end else if (res_above || res_below) begin
                        if (f_spent) begin
                            set_fail = 1'b1;
                            state_d  = ST_IDLE;
                        end else if (res_above) begin
                            kind_d  = PK_SET;
                            state_d = ST_FPULSE;
                            if (bl_at_ceil) wl_bump = 1'b1;
                            else            bl_adv  = 1'b1;
                        end else begin
                            kind_d  = PK_RESET;
                            state_d = ST_FPULSE;
                            sl_adv  = 1'b1;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and operation registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= PK_SET;
            range_q  <= '0;
            climit_q <= '0;
            flimit_q <= '0;
            wl_lvl_q <= '0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            if (start_acc) begin
                range_q  <= range_i;
                climit_q <= coarse_limit_i;
                flimit_q <= fine_limit_i;
                done_q   <= 1'b0;
                fail_q   <= set_fail;
            end else begin
                if (set_done) done_q <= 1'b1;
                if (set_fail) fail_q <= 1'b1;
            end
            if (wl_load)
                wl_lvl_q <= cfg.wl_start;
            else if (wl_bump && wl_lvl_q != WL_MAX)
                wl_lvl_q <= wl_lvl_q + 1'b1;
        end
    end

    // outputs by state
    always_comb begin
        pulse_req_o  = 1'b0;
        verify_req_o = 1'b0;
        pulse_kind_o = 1'b0;
        bl_code_o    = '0;
        sl_code_o    = '0;
        wl_code_o    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CPULSE: begin
                pulse_req_o  = 1'b1;
                pulse_kind_o = PK_SET;
                bl_code_o    = cfg.coarse_bl;
                wl_code_o    = cfg.wl_start;
            end
            ST_FPULSE: begin
                pulse_req_o  = 1'b1;
                pulse_kind_o = kind_q;
                wl_code_o    = wl_lvl_q;
                if (kind_q == PK_SET) bl_code_o = bl_lvl;
                else                  sl_code_o = sl_lvl;
            end
            ST_CVERIFY, ST_FVERIFY: verify_req_o = 1'b1;
            default: ;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign fail_o = fail_q;

    // R2
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_req_o && verify_req_o));

    // R2
    pulse_codes_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_req_o && !pulse_ack_i |=>
            $stable(bl_code_o) && $stable(sl_code_o) && $stable(wl_code_o) && $stable(pulse_kind_o));

    // R2
    pulse_then_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_req_o && pulse_ack_i |=> verify_req_o);

    // R10
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    // R10
    flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> !busy_o);

    // R11
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(range_q) && $stable(climit_q) && $stable(flimit_q));

    // R5
    fine_bl_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FPULSE) |-> bl_code_o <= cfg.fbl_ceil);

endmodule

// File: tb/sim_rram_wv_ctrl.sv
module sim_rram_wv_ctrl;

    localparam int DW = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    range_i = '0;
    logic [CW-1:0] coarse_limit_i = '0;
    logic [CW-1:0] fine_limit_i = '0;
    logic          pulse_req_o, pulse_kind_o;
    logic [DW-1:0] bl_code_o, sl_code_o, wl_code_o;
    logic          pulse_ack_i = 1'b0;
    logic          verify_req_o;
    logic          verify_ack_i = 1'b0;
    logic          vfy_in_i = 1'b0, vfy_above_i = 1'b0, vfy_below_i = 1'b0;
    logic          busy_o, done_o, fail_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [30:0] exp_q[$];
    logic [2:0]  resp_q[$];
    int          scen[$];

    always #10 clk = ~clk;

    rram_wv_ctrl u0 (
        .clk, .rst_n, .start_i, .range_i, .coarse_limit_i, .fine_limit_i,
        .pulse_req_o, .pulse_kind_o, .bl_code_o, .sl_code_o, .wl_code_o,
        .pulse_ack_i, .verify_req_o, .verify_ack_i,
        .vfy_in_i, .vfy_above_i, .vfy_below_i,
        .busy_o, .done_o, .fail_o
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [30:0] pk(int kind, int bl, int sl, int wl);
        return {kind[0], bl[9:0], sl[9:0], wl[9:0]};
    endfunction

    // responder and monitor: acknowledges requests, compares pulses
    initial begin
        forever begin
            @(negedge clk);
            if (pulse_ack_i) begin
                pulse_ack_i = 1'b0;
            end else if (pulse_req_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected pulse", int'(bl_code_o), 0);
                end else begin
                    logic [30:0] e;
                    logic [30:0] a;
                    e = exp_q.pop_front();
                    a = {pulse_kind_o, bl_code_o, sl_code_o, wl_code_o};
                    // R1 R5 R6 R7: pulse kind and codes
                    check(a == e, "R1/R5/R6/R7", "pulse", int'(a), int'(e));
                end
                pulse_ack_i = 1'b1;
            end
            if (verify_ack_i) begin
                verify_ack_i = 1'b0;
                {vfy_in_i, vfy_above_i, vfy_below_i} = 3'b000;
            end else if (verify_req_o) begin
                if (resp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected verify", 1, 0);
                end else begin
                    {vfy_in_i, vfy_above_i, vfy_below_i} = resp_q.pop_front();
                end
                verify_ack_i = 1'b1;
            end
        end
    end

    // code: 1 in window, 2 above, 3 below, 0 no flag
    task automatic run_op(input int r, input int cl, input int fl, input bit ign, input string tag);
        int  ccnt = 0, fcnt = 0, outcome = 0, wl, bl = 0, sl = 0;
        bit  coarse = 1'b1, blseen = 1'b0, slseen = 1'b0;
        int  guard;
        wl = 286 + 4 * r;
        if (cl == 0) outcome = 2;
        else begin exp_q.push_back(pk(0, 200, 0, wl)); ccnt = 1; end
        foreach (scen[i]) begin
            if (outcome != 0) break;
            case (scen[i])
                1: resp_q.push_back(3'b100);
                2: resp_q.push_back(3'b010);
                3: resp_q.push_back(3'b001);
                default: resp_q.push_back(3'b000);
            endcase
            if (scen[i] == 1) outcome = 1;
            else if (scen[i] == 0) ;
            else if (coarse && scen[i] == 2) begin
                if (ccnt == cl) outcome = 2;
                else begin exp_q.push_back(pk(0, 200, 0, wl)); ccnt++; end
            end else begin
                coarse = 1'b0;
                if (fcnt == fl) outcome = 2;
                else if (scen[i] == 2) begin
                    if (blseen && bl == 400) wl++;
                    else if (!blseen) begin bl = 120 + 10 * r; blseen = 1'b1; end
                    else bl = (bl + 20 > 400) ? 400 : bl + 20;
                    exp_q.push_back(pk(0, bl, 0, wl));
                    fcnt++;
                end else begin
                    if (!slseen) begin sl = 150 + 10 * r; slseen = 1'b1; end
                    else sl = (sl + 10 > 350) ? 350 : sl + 10;
                    exp_q.push_back(pk(1, 0, sl, wl));
                    fcnt++;
                end
            end
        end
        @(negedge clk);
        start_i = 1'b1; range_i = r[1:0];
        coarse_limit_i = CW'(cl); fine_limit_i = CW'(fl);
        @(negedge clk);
        start_i = 1'b0;
        // R10 R1: flags cleared or immediate fail on accepted start
        if (cl == 0) check(fail_o && !busy_o, "R8", {tag, " zero budget"}, int'(fail_o), 1);
        else check(!done_o && !fail_o && busy_o, "R10", {tag, " flags cleared, busy"},
                   int'({done_o, fail_o, busy_o}), 1);
        if (ign) begin
            // R11: second start while busy with other range and zero budget
            start_i = 1'b1; range_i = ~r[1:0]; coarse_limit_i = '0; fine_limit_i = '0;
            @(negedge clk);
            start_i = 1'b0;
        end
        guard = 0;
        while (busy_o && guard < 5000) begin @(negedge clk); guard++; end
        repeat (2) @(negedge clk);
        check(done_o == (outcome == 1) && fail_o == (outcome == 2) && !busy_o,
              (outcome == 2) ? "R8/R9" : "R4", {tag, " outcome"},
              int'({done_o, fail_o}), (outcome == 1) ? 2 : 1);
        check(exp_q.size() == 0 && resp_q.size() == 0, "R3", {tag, " sequence length"},
              exp_q.size() + resp_q.size(), 0);
        exp_q.delete(); resp_q.delete();
    endtask

    // watchdog
    initial begin
        while (cycles < 150000) begin @(posedge clk); cycles++; end
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected 0", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(!pulse_req_o && !verify_req_o && !busy_o && !done_o && !fail_o &&
              bl_code_o == 0 && sl_code_o == 0 && wl_code_o == 0,
              "R12", "reset outputs", int'({pulse_req_o, verify_req_o, busy_o, done_o, fail_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o, "R12", "idle after reset", int'(busy_o), 0);

        // R1 R4: coarse pulse lands in window
        scen = {1};
        run_op(0, 4, 8, 1'b0, "coarse hit");
        // R10: done held
        repeat (3) @(negedge clk);
        check(done_o && !fail_o, "R10", "done held", int'({done_o, fail_o}), 2);

        // R3: no-flag results, repeated coarse SET
        scen = {0, 2, 0, 1};
        run_op(1, 4, 8, 1'b0, "noflag");

        // R6: fine resets then in window
        scen = {3, 3, 1};
        run_op(2, 3, 8, 1'b0, "fine reset");

        // R5 R7: SET sweep to bitline ceiling then wordline steps
        scen = {3};
        for (int i = 0; i < 17; i++) scen.push_back(2);
        scen.push_back(1);
        run_op(1, 2, 40, 1'b0, "bl ceiling wl escalation");

        // R6: sourceline cap at 350
        scen = {};
        for (int i = 0; i < 22; i++) scen.push_back(3);
        scen.push_back(1);
        run_op(0, 1, 30, 1'b0, "sl cap");

        // R8: coarse budget exhausted
        scen = {2, 2};
        run_op(3, 2, 8, 1'b0, "coarse budget");
        // R8: zero coarse budget
        scen = {};
        run_op(2, 0, 8, 1'b0, "coarse zero");
        // R9: fine budget exhausted
        scen = {3, 3, 3};
        run_op(0, 1, 2, 1'b0, "fine budget");
        // R9: zero fine budget
        scen = {3};
        run_op(2, 1, 0, 1'b0, "fine zero");

        // R11: start ignored while busy
        scen = {3, 2, 1};
        run_op(2, 3, 6, 1'b1, "start while busy");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule